// File: doc/BRIEF.md
# Statistics Counter Update Engine

The block keeps a small array of counters in a local synchronous memory and changes them only through commands from a controller. Each command names a counter address, a kind, an operation code and an operand. The command always takes the same route: it is accepted, the counter is read, the ALU computes a result, and the result is written back while any response is returned. Only one command is in flight at a time.

Three command kinds exist. An update command applies the operation and writes the result. A read command returns the stored value and leaves memory alone. A combined command both updates and answers, and returns either the old value or the new one. The ALU provides logic operations, replace, saturating increment, decrement, add and subtract, and wrapping increment and decrement. A sticky interrupt records any saturating operation that hit a limit. After reset the block clears every counter to zero before it first raises ready.

Top module: `stat_engine`

## Requirements
- R1: After reset is released, cmd_ready stays low for exactly DEPTH clock cycles while every entry is written with zero. It is first seen high at the DEPTH-th falling edge, and every entry then reads zero.
- R2: A command is taken on a rising edge where cmd_valid and cmd_ready are both high. cmd_ready then stays low and is high again exactly four cycles after the accepting edge, so at most one command is in flight.
- R3: A read command (cmd_kind 2'b01) returns the stored value of cmd_addr. It modifies no entry and leaves irq unchanged.
- R4: An update command (cmd_kind 2'b00) writes the result to cmd_addr. Op 0 keeps the entry, op 1 replaces it with cmd_data, op 2/3/4 give the bitwise AND/OR/XOR with cmd_data, and ops 11 to 15 act like op 0.
- R5: Op 5 (increment) and op 6 (decrement) saturate. Incrementing all-ones or decrementing zero leaves the entry at that limit.
- R6: Op 7 adds cmd_data and op 8 subtracts cmd_data. A sum above all-ones gives all-ones, and a difference below zero gives zero.
- R7: Op 9 and op 10 increment and decrement modulo 2^W. All-ones plus one is zero, and zero minus one is all-ones.
- R8: A combined command (cmd_kind 2'b10 or 2'b11) writes the result like an update. With cmd_form=1 it returns the new value, and with cmd_form=0 it returns the value held before the update.
- R9: rsp_valid is a one-cycle pulse. It rises on the same edge that raises cmd_ready after a read or combined command, and it never pulses for an update command.
- R10: irq is set at write-back when op 5 or op 7 would exceed all-ones, or op 6 or op 8 would fall below zero, in an update or combined command. It stays set until a cycle with irq_clr high. If a set and a clear land on the same edge, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block can take a command |
| cmd_kind | input | 2 | 00 update, 01 read, 1x combined |
| cmd_form | input | 1 | Combined response: 1 new value, 0 old value |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | AW | Counter address |
| cmd_data | input | W | Operand |
| rsp_valid | output | 1 | Response pulse |
| rsp_data | output | W | Returned counter value |
| irq | output | 1 | Sticky limit flag |
| irq_clr | input | 1 | Clears irq |

## Verification
The hardest cases to reach are the saturation and wrap edges. Each needs a counter that already holds a limit value before the arithmetic command arrives, and the limit has to be put there through the same command port. The bench therefore loads each boundary value with a replace command and then applies every operation code with every boundary operand through a combined command. It alternates the response form and checks the returned value, the stored value, and whether irq is set and stays set.

// File: rtl/stat_pkg.sv
package stat_pkg;
  typedef enum logic [1:0] {
    K_UPD  = 2'b00,
    K_READ = 2'b01,
    K_BOTH = 2'b10,
    K_BOTH2 = 2'b11
  } kind_t;

  typedef enum logic [3:0] {
    OP_KEEP = 4'd0, OP_PUT  = 4'd1, OP_AND  = 4'd2, OP_OR   = 4'd3,
    OP_XOR  = 4'd4, OP_INCS = 4'd5, OP_DECS = 4'd6, OP_ADDS = 4'd7,
    OP_SUBS = 4'd8, OP_INCW = 4'd9, OP_DECW = 4'd10
  } op_t;

  typedef enum logic [2:0] {
    ST_CLEAR, ST_IDLE, ST_FETCH, ST_EXEC, ST_WB
  } phase_t;
endpackage

// File: rtl/stat_ram.sv
module stat_ram #(
  parameter int W = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/stat_alu.sv
module stat_alu
  import stat_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] arg,
  output logic [W-1:0] res,
  output logic         hit_limit
);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic [W:0] sum, dif, up, dn;

  always_comb begin
    sum = {1'b0, cur} + {1'b0, arg};
    dif = {1'b0, cur} - {1'b0, arg};
    up  = {1'b0, cur} + {{W{1'b0}}, 1'b1};
    dn  = {1'b0, cur} - {{W{1'b0}}, 1'b1};
    res = cur;
    hit_limit = 1'b0;
    case (op)
      OP_PUT:  res = arg;
      OP_AND:  res = cur & arg;
      OP_OR:   res = cur | arg;
      OP_XOR:  res = cur ^ arg;
      OP_INCS: begin res = up[W] ? cur : up[W-1:0];  hit_limit = up[W]; end
      OP_DECS: begin res = dn[W] ? cur : dn[W-1:0];  hit_limit = dn[W]; end
      OP_ADDS: begin res = sum[W] ? ALL1 : sum[W-1:0]; hit_limit = sum[W]; end
      OP_SUBS: begin res = dif[W] ? '0 : dif[W-1:0]; hit_limit = dif[W]; end
      OP_INCW: res = up[W-1:0];
      OP_DECW: res = dn[W-1:0];
      default: res = cur;
    endcase
  end
endmodule

// File: rtl/stat_engine.sv
module stat_engine
  import stat_pkg::*;
#(
  parameter int W = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [1:0]    cmd_kind,
  input  logic          cmd_form,
  input  logic [3:0]    cmd_op,
  input  logic [AW-1:0] cmd_addr,
  input  logic [W-1:0]  cmd_data,
  output logic          rsp_valid,
  output logic [W-1:0]  rsp_data,
  output logic          irq,
  input  logic          irq_clr
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [W-1:0]  ALL1 = {W{1'b1}};

  phase_t        phase;
  logic [AW-1:0] clr_ptr;
  logic [1:0]    k_q;
  logic          f_q;
  logic [3:0]    op_q;
  logic [AW-1:0] a_q;
  logic [W-1:0]  d_q;
  logic [W-1:0]  old_q, new_q;
  logic          lim_q;
  logic          ready_q, rsp_q, irq_q;
  logic [W-1:0]  rsp_d_q;

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_wa;
  logic [W-1:0]  mem_wd, mem_rd;
  logic [W-1:0]  alu_res;
  logic          alu_lim;
  logic          writes;

  assign writes = (k_q != K_READ);
  assign mem_re = (phase == ST_FETCH);
  always_comb begin
    mem_we = 1'b0;
    mem_wa = a_q;
    mem_wd = new_q;
    if (phase == ST_CLEAR) begin
      mem_we = 1'b1;
      mem_wa = clr_ptr;
      mem_wd = '0;
    end else if (phase == ST_WB && writes) begin
      mem_we = 1'b1;
    end
  end

  stat_ram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(mem_we), .waddr(mem_wa), .wdata(mem_wd),
    .re(mem_re), .raddr(a_q), .rdata(mem_rd)
  );

  stat_alu #(.W(W)) u_alu (
    .op(op_q), .cur(mem_rd), .arg(d_q), .res(alu_res), .hit_limit(alu_lim)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= ST_CLEAR;
      clr_ptr <= '0;
      ready_q <= 1'b0;
      rsp_q   <= 1'b0;
      rsp_d_q <= '0;
      irq_q   <= 1'b0;
      k_q <= '0; f_q <= 1'b0; op_q <= '0; a_q <= '0; d_q <= '0;
      old_q <= '0; new_q <= '0; lim_q <= 1'b0;
    end else begin
      rsp_q <= 1'b0;
      irq_q <= irq_q & ~irq_clr;
      case (phase)
        ST_CLEAR: begin
          clr_ptr <= clr_ptr + 1'b1;
          if (clr_ptr == LAST) begin
            phase   <= ST_IDLE;
            ready_q <= 1'b1;
          end
        end
        ST_IDLE: if (cmd_valid && ready_q) begin
          k_q <= cmd_kind; f_q <= cmd_form; op_q <= cmd_op;
          a_q <= cmd_addr; d_q <= cmd_data;
          ready_q <= 1'b0;
          phase   <= ST_FETCH;
        end
        ST_FETCH: phase <= ST_EXEC;
        ST_EXEC: begin
          old_q <= mem_rd;
          new_q <= alu_res;
          lim_q <= alu_lim;
          phase <= ST_WB;
        end
        ST_WB: begin
          ready_q <= 1'b1;
          phase   <= ST_IDLE;
          if (k_q != K_UPD) begin
            rsp_q   <= 1'b1;
            rsp_d_q <= (k_q == K_READ || !f_q) ? old_q : new_q;
          end
          if (writes && lim_q) irq_q <= 1'b1;
        end
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready = ready_q;
  assign rsp_valid = rsp_q;
  assign rsp_data  = rsp_d_q;
  assign irq       = irq_q;

  assert_single_flight_R2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);
  assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  assert_rsp_with_ready_R9: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> cmd_ready);
  assert_read_no_write_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && phase != ST_CLEAR) |-> (k_q != K_READ));
  assert_inc_sat_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op_q == OP_INCS && mem_rd == ALL1) |=> (new_q == ALL1 && lim_q));
  assert_dec_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op_q == OP_DECW && mem_rd == '0) |=> (new_q == ALL1 && !lim_q));
  assert_sub_floor_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_EXEC && op_q == OP_SUBS && mem_rd < d_q) |=> (new_q == '0));
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (irq && !irq_clr) |=> irq);
  assert_no_ready_clearing_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == ST_CLEAR) |-> !cmd_ready);
endmodule

// File: tb/stat_engine_test.sv
module stat_engine_test;
  localparam int W = 16;
  localparam int DEPTH = 16;
  localparam int AW = $clog2(DEPTH);
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [1:0] cmd_kind = '0;
  logic cmd_form = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic [W-1:0] cmd_data = '0;
  logic rsp_valid;
  logic [W-1:0] rsp_data;
  logic irq;
  logic irq_clr = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  stat_engine #(.W(W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_kind(cmd_kind), .cmd_form(cmd_form), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .irq(irq), .irq_clr(irq_clr)
  );

  task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [W-1:0] boundary(input int i);
    case (i)
      0: return '0;
      1: return 1;
      2: return {1'b0, {(W-1){1'b1}}};
      3: return {1'b1, {(W-1){1'b0}}};
      4: return ALL1 - 1;
      default: return ALL1;
    endcase
  endfunction

  function automatic logic [W:0] model(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
    longint s;
    case (op)
      1: return {1'b0, b};
      2: return {1'b0, a & b};
      3: return {1'b0, a | b};
      4: return {1'b0, a ^ b};
      5: return (a == ALL1) ? {1'b1, a} : {1'b0, a + 1'b1};
      6: return (a == 0) ? {1'b1, a} : {1'b0, a - 1'b1};
      7: begin s = longint'(a) + longint'(b);
         return (s > longint'(ALL1)) ? {1'b1, ALL1} : {1'b0, W'(s)}; end
      8: begin s = longint'(a) - longint'(b);
         return (s < 0) ? {1'b1, {W{1'b0}}} : {1'b0, W'(s)}; end
      9: return {1'b0, W'(a + 1'b1)};
      10: return {1'b0, W'(a - 1'b1)};
      default: return {1'b0, a};
    endcase
  endfunction

  task automatic run_cmd(input logic [1:0] k, input logic f, input int op,
                         input int adr, input logic [W-1:0] d,
                         output logic got_rsp, output logic [W-1:0] rd, output int lat);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_kind = k; cmd_form = f; cmd_op = 4'(op);
    cmd_addr = AW'(adr); cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!cmd_ready && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    got_rsp = rsp_valid;
    rd = rsp_data;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    logic g;
    logic [W-1:0] r;
    int lat;
    int n;
    logic [W:0] m;
    logic [W-1:0] va, vb;
    repeat (3) @(negedge clk);
    check("R1 reset ready", {15'b0, cmd_ready}, 0);
    rst = 1'b0;
    n = 0;
    while (!cmd_ready && n < 100) begin @(negedge clk); n++; end
    check("R1 clear length", W'(n), W'(DEPTH));

    for (int a = 0; a < DEPTH; a++) begin
      run_cmd(2'b01, 1'b0, 0, a, '0, g, r, lat);
      check("R1 cleared entry", r, '0);
      check("R9 read pulses", {15'b0, g}, 1);
    end
    run_cmd(2'b00, 1'b0, 1, 3, 16'h1234, g, r, lat);
    check("R2 latency", W'(lat), 4);
    check("R9 no pulse for update", {15'b0, g}, 0);
    run_cmd(2'b01, 1'b0, 5, 3, 16'hFFFF, g, r, lat);
    check("R3 read value", r, 16'h1234);
    run_cmd(2'b01, 1'b0, 5, 3, 16'hFFFF, g, r, lat);
    check("R3 read no change", r, 16'h1234);

    n = 0;
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++) begin
          int adr;
          logic fm;
          adr = n % DEPTH;
          fm = n[0];
          n++;
          va = boundary(i);
          vb = boundary(j);
          irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
          check("R10 cleared", {15'b0, irq}, 0);
          run_cmd(2'b00, 1'b0, 1, adr, va, g, r, lat);
          m = model(op, va, vb);
          run_cmd(op[0] ? 2'b11 : 2'b10, fm, op, adr, vb, g, r, lat);
          check("R8 combined resp", r, fm ? m[W-1:0] : va);
          check("R10 flag", {15'b0, irq}, {15'b0, m[W]});
          run_cmd(2'b01, 1'b0, 0, adr, '0, g, r, lat);
          if (op == 5 || op == 6) check("R5 sat inc/dec", r, m[W-1:0]);
          else if (op == 7 || op == 8) check("R6 sat add/sub", r, m[W-1:0]);
          else if (op == 9 || op == 10) check("R7 wrap", r, m[W-1:0]);
          else check("R4 update ops", r, m[W-1:0]);
          check("R10 sticky over read", {15'b0, irq}, {15'b0, m[W]});
        end

    run_cmd(2'b00, 1'b0, 1, 5, ALL1, g, r, lat);
    run_cmd(2'b00, 1'b0, 5, 5, '0, g, r, lat);
    check("R10 set by update", {15'b0, irq}, 1);
    repeat (3) @(negedge clk);
    check("R10 held idle", {15'b0, irq}, 1);
    run_cmd(2'b01, 1'b0, 0, 5, '0, g, r, lat);
    check("R5 stays max", r, ALL1);
    finish_up();
  end
endmodule